// File: doc/BRIEF.md
# Abort Shutdown State Controller

This block tracks what one processor core does once its virtualization layer raises a fatal abort. An abort request carries a small indicator code. The block stores that code first. It then picks one of two exits, based on whether the core is inside a secure launch session at that moment.

Inside a session, the core moves to a trusted-shutdown state and presents a fixed error code. Outside a session, the block drives a one-cycle notification pulse toward the chipset, then parks the core in a latched abort-shutdown state. Only reset leaves either terminal state.

The session flag is derived from two instruction strobes. An enter strobe opens a session and an exit strobe closes it. The block also gates six incoming event classes: they pass through while the core runs and are blocked once it has left the run state. Executing the instructions and writing the indicator to memory are handled elsewhere.

Top module: `vabort_shutdown_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0 (run), err_code_o is 0, saved_ind_o is 0 and notify_o is 0. Reset also clears the session flag.
- R2: A clock edge in the run state with abort_req_i high stores abort_ind_i, and the stored value appears on saved_ind_o after that edge.
- R3: If the session flag is set when the request is taken, state_o becomes 3 (trusted shutdown) after that edge, err_code_o becomes 0x000D and notify_o stays low.
- R4: If the session flag is clear when the request is taken, state_o becomes 1 (notify) for exactly one cycle with notify_o high, and then becomes 2 (abort shutdown).
- R5: notify_o is high for one cycle only, once per abort, even if the request stays asserted.
- R6: States 2 and 3 are left only by reset. Requests, strobes and events do not change state_o.
- R7: evt_fwd_o equals evt_i in state 0 and is all zero in every other state. The bit order is: bit0 machine check, bit1 INIT, bit2 external interrupt, bit3 NMI, bit4 start-up IPI, bit5 SMI.
- R8: The session flag is set by sec_enter_i and cleared by sec_exit_i, and exit wins when both arrive together. The flag is clear if no enter strobe has ever occurred. A request uses the flag value from before the current edge, so a strobe in the same cycle as the request does not affect the chosen path.
- R9: A request that arrives outside the run state has no effect: saved_ind_o and err_code_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_req_i | input | 1 | Abort request |
| abort_ind_i | input | IND_W | Indicator code that comes with the request |
| sec_enter_i | input | 1 | Strobe: secure session entered |
| sec_exit_i | input | 1 | Strobe: secure session exited |
| evt_i | input | N_EVT | Incoming event classes |
| state_o | output | 2 | 0 run, 1 notify, 2 abort shutdown, 3 trusted shutdown |
| err_code_o | output | ERR_W | Trusted-shutdown error code |
| notify_o | output | 1 | Chipset notification pulse |
| saved_ind_o | output | IND_W | Stored abort indicator |
| evt_fwd_o | output | N_EVT | Events passed on while running |

## Verification
The assertions assume that every input is synchronous to clk_i and is stable around the rising edge. They also assume that reset is applied before any request is made. The bench changes inputs only on the falling edge and starts every scenario with a full reset. It holds requests for several cycles and drives the strobes in the same cycle as a request, so the rules on taking only the first request and on using the earlier flag value are both exercised.

// File: rtl/vabort_pkg.sv
package vabort_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_NOTIFY = 2'd1,
    ST_HALT   = 2'd2,
    ST_TRUST  = 2'd3
  } core_st_e;
endpackage

// File: rtl/vabort_secure_track.sv
module vabort_secure_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic exit_i,
  output logic secure_o
);
  logic sec_q;

  // exit takes priority over enter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= 1'b0;
    else if (exit_i)  sec_q <= 1'b0;
    else if (enter_i) sec_q <= 1'b1;
  end

  assign secure_o = sec_q;

  a_r8_enter_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && !exit_i) |=> secure_o);
  a_r8_exit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_i |=> !secure_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enter_i && !exit_i) |=> $stable(secure_o));
endmodule

// File: rtl/vabort_fsm.sv
module vabort_fsm
  import vabort_pkg::*;
#(
  parameter int unsigned IND_W     = 3,
  parameter int unsigned ERR_W     = 16,
  parameter logic [ERR_W-1:0] TRUST_ERR = 16'h000D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IND_W-1:0] ind_i,
  input  logic             secure_i,
  output core_st_e         state_o,
  output logic             notify_o,
  output logic [ERR_W-1:0] err_o,
  output logic [IND_W-1:0] ind_o
);
  core_st_e         st_q, st_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [IND_W-1:0] ind_q, ind_d;

  always_comb begin
    st_d  = st_q;
    err_d = err_q;
    ind_d = ind_q;
    unique case (st_q)
      ST_RUN: if (req_i) begin
        ind_d = ind_i;  // indicator is stored before the path is chosen
        if (secure_i) begin
          st_d  = ST_TRUST;
          err_d = TRUST_ERR;
        end else begin
          st_d  = ST_NOTIFY;
        end
      end
      ST_NOTIFY: st_d = ST_HALT;
      default:   st_d = st_q;  // terminal states
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      err_q <= '0;
      ind_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      ind_q <= ind_d;
    end
  end

  assign state_o  = st_q;
  assign notify_o = (st_q == ST_NOTIFY);
  assign err_o    = err_q;
  assign ind_o    = ind_q;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && req_i) |=> ind_o == $past(ind_i));
  a_r3_trust_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRUST) |-> (err_o == TRUST_ERR && !notify_o));
  a_r4_notify_to_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NOTIFY) |=> (st_q == ST_HALT));
  a_r5_notify_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |=> !notify_o);
  a_r6_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALT) |=> (st_q == ST_HALT));
  a_r6_trust_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRUST) |=> (st_q == ST_TRUST));
  a_r9_req_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_RUN) |=> ($stable(ind_o) && $stable(err_o)));
endmodule

// File: rtl/vabort_evt_gate.sv
module vabort_evt_gate
  import vabort_pkg::*;
#(
  parameter int unsigned N_EVT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  core_st_e         state_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_EVT-1:0] evt_o
);
  logic run;
  assign run = (state_i == ST_RUN);

  for (genvar g = 0; g < N_EVT; g++) begin : g_gate
    assign evt_o[g] = evt_i[g] & run;
  end

  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_RUN) |-> (evt_o == '0));
  a_r7_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN) |-> (evt_o == evt_i));
endmodule

// File: rtl/vabort_shutdown_ctrl.sv
module vabort_shutdown_ctrl
  import vabort_pkg::*;
#(
  parameter int unsigned IND_W = 3,
  parameter int unsigned ERR_W = 16,
  parameter int unsigned N_EVT = 6,
  parameter logic [ERR_W-1:0] TRUST_ERR = 16'h000D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_req_i,
  input  logic [IND_W-1:0] abort_ind_i,
  input  logic             sec_enter_i,
  input  logic             sec_exit_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic [1:0]       state_o,
  output logic [ERR_W-1:0] err_code_o,
  output logic             notify_o,
  output logic [IND_W-1:0] saved_ind_o,
  output logic [N_EVT-1:0] evt_fwd_o
);
  logic     secure;
  core_st_e st;

  vabort_secure_track u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enter_i  (sec_enter_i),
    .exit_i   (sec_exit_i),
    .secure_o (secure)
  );

  vabort_fsm #(
    .IND_W     (IND_W),
    .ERR_W     (ERR_W),
    .TRUST_ERR (TRUST_ERR)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (abort_req_i),
    .ind_i    (abort_ind_i),
    .secure_i (secure),
    .state_o  (st),
    .notify_o (notify_o),
    .err_o    (err_code_o),
    .ind_o    (saved_ind_o)
  );

  vabort_evt_gate #(.N_EVT(N_EVT)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (st),
    .evt_i   (evt_i),
    .evt_o   (evt_fwd_o)
  );

  assign state_o = st;

  a_r5_notify_only_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && abort_req_i && secure) |=> !notify_o);
endmodule

// File: tb/vabort_shutdown_ctrl_tb.sv
`timescale 1ns/1ps
module vabort_shutdown_ctrl_tb;
  localparam int IND_W = 3;
  localparam int ERR_W = 16;
  localparam int N_EVT = 6;

  typedef struct packed {
    logic [1:0]       st;
    logic             nt;
    logic [ERR_W-1:0] err;
    logic [IND_W-1:0] ind;
    logic [N_EVT-1:0] ev;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, ent = 1'b0, ext = 1'b0;
  logic [IND_W-1:0] ind = '0;
  logic [N_EVT-1:0] evt = '0;
  logic [1:0] st_o;
  logic [ERR_W-1:0] err_o;
  logic nt_o;
  logic [IND_W-1:0] ind_o;
  logic [N_EVT-1:0] ev_o;

  int n_chk = 0, n_fail = 0;
  exp_t  q[$];
  string tq[$];

  // reference model state
  logic [1:0] m_st = 2'd0;
  logic m_sec = 1'b0;
  logic [ERR_W-1:0] m_err = '0;
  logic [IND_W-1:0] m_ind = '0;

  always #4 clk = ~clk;  // 125 MHz

  vabort_shutdown_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .abort_req_i(req), .abort_ind_i(ind),
    .sec_enter_i(ent), .sec_exit_i(ext), .evt_i(evt),
    .state_o(st_o), .err_code_o(err_o), .notify_o(nt_o),
    .saved_ind_o(ind_o), .evt_fwd_o(ev_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic cyc(logic r, logic [IND_W-1:0] i, logic en, logic ex,
                     logic [N_EVT-1:0] e, string tag);
    exp_t x;
    @(negedge clk);
    req = r; ind = i; ent = en; ext = ex; evt = e;
    case (m_st)
      2'd0: if (r) begin
        m_ind = i;
        if (m_sec) begin m_st = 2'd3; m_err = 16'h000D; end
        else m_st = 2'd1;
      end
      2'd1: m_st = 2'd2;
      default: ;
    endcase
    if (ex) m_sec = 1'b0; else if (en) m_sec = 1'b1;
    x.st = m_st; x.nt = (m_st == 2'd1); x.err = m_err; x.ind = m_ind;
    x.ev = (m_st == 2'd0) ? e : '0;
    q.push_back(x);
    tq.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      string t;
      x = q.pop_front();
      t = tq.pop_front();
      chk(t, {33'd0, st_o, nt_o, err_o, ind_o, ev_o}, {33'd0, x});
    end
  end

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0; req = 0; ent = 0; ext = 0; ind = '0; evt = '0;
    #1;
    chk("R1 reset outputs", {38'd0, st_o, nt_o, err_o, ind_o}, 64'd0);
    m_st = 0; m_sec = 0; m_err = '0; m_ind = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    cyc(0, 0, 0, 0, 6'b101010, "R7 events pass in run");
    cyc(0, 0, 0, 0, 6'b010101, "R7 events pass in run");
    // plain path, flag never set (R8), request held two cycles (R5)
    cyc(1, 3'd5, 0, 0, 6'b111111, "R4 R2 notify and capture");
    cyc(1, 3'd2, 0, 0, 6'b111111, "R5 R9 held request, to halt");
    cyc(1, 3'd6, 1, 0, 6'b111111, "R6 R7 R9 halt ignores all");
    cyc(0, 0, 0, 1, 6'b000001, "R6 halt sticky");
    cyc(0, 0, 0, 0, 6'b100000, "R5 no second pulse");
    // secure path
    do_reset();
    cyc(0, 0, 1, 0, 0, "R8 enter strobe");
    cyc(1, 3'd3, 0, 0, 6'b001000, "R3 trusted shutdown code");
    cyc(1, 3'd7, 0, 1, 6'b111111, "R9 R7 trusted ignores request");
    cyc(0, 0, 1, 0, 6'b000010, "R6 trusted sticky");
    // enter then exit -> plain path
    do_reset();
    cyc(0, 0, 1, 0, 0, "R8 enter");
    cyc(0, 0, 0, 1, 0, "R8 exit");
    cyc(1, 3'd1, 0, 0, 0, "R8 exit closes session");
    cyc(0, 0, 0, 0, 0, "R4 to halt");
    // both strobes together -> cleared
    do_reset();
    cyc(0, 0, 1, 0, 0, "R8 enter");
    cyc(0, 0, 1, 1, 0, "R8 both strobes");
    cyc(1, 3'd4, 0, 0, 0, "R8 exit wins");
    // strobe in request cycle uses old flag
    do_reset();
    cyc(1, 3'd2, 1, 0, 0, "R8 same-cycle enter ignored");
    cyc(0, 0, 0, 0, 0, "R4 halt after notify");
    do_reset();
    cyc(0, 0, 1, 0, 0, "R8 enter");
    cyc(1, 3'd6, 0, 1, 0, "R8 same-cycle exit ignored, trusted");
    cyc(0, 0, 0, 0, 6'b111111, "R7 masked in trusted");
    do_reset();
    cyc(0, 0, 0, 0, 6'b011011, "R1 R7 run after reset");
    wait (q.size() == 0);
    #10;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule